// File: doc/BRIEF.md
# Radio burst dibit deframer

This block takes a stream of 2-bit symbols and splits one 144-symbol digital radio data burst into its fields. A one-cycle `start_i` pulse arms the block. Each later cycle with `valid_i` high delivers one dibit. The fields arrive in a fixed order:

| Dibits | Field |
|---|---|
| 12 | control header |
| 49 | first payload half |
| 5 | first slot-type half |
| 24 | sync/signalling |
| 5 | second slot-type half |
| 49 | second payload half |

Each dibit gives two bits, the high bit first. An optional polarity flip is applied to every symbol on arrival.

The header is de-interleaved through a fixed permutation. Its first seven bits form an access word protected by a Hamming(7,4) code, and that word yields the timeslot. The twenty slot-type bits are decoded as a shortened Golay(20,8) word, which gives a 4-bit color code and a 4-bit burst type. The sign bits of the sync field are matched against three programmable patterns: base-station data, direct-mode slot 0 and direct-mode slot 1. The two direct-mode matches override the timeslot.

One cycle after the last dibit, all results are registered and `done_o` pulses. If either decode fails, `fail_o` pulses with it.

Top module: `burst_deframer`

## Requirements
- R1: `payload_o[k]` is the k-th payload bit in arrival order. Bits 0..97 come from dibits 12..60 and bits 98..195 from dibits 95..143. Each dibit contributes its high bit, then its low bit.
- R2: When `invert_i` is 1, each accepted dibit is XORed with binary 10 before any other use.
- R3: Header bit n (n = 0..23, two per dibit, high first) is written to `hdr_o[P[n]]`, with P = 0,7,8,9,1,10,11,12,2,13,14,15,3,16,4,17,18,19,5,20,21,22,6,23.
- R4: The access word is a = `hdr_o[6:0]`. Bits a0..a3 are data, with a4 = a0^a1^a2, a5 = a1^a2^a3 and a6 = a0^a1^a3. The timeslot is the decoded a1.
  - With HDR_CORRECT=1, one flipped bit is corrected and `hdr_err_o` stays 0.
  - With HDR_CORRECT=0, any parity mismatch sets `hdr_err_o`.
- R5: When `mobile_i` is 1 in the cycle after the last dibit, the timeslot is 0 unless a direct-mode sync matched.
- R6: The slot-type word s0..s19 is taken in arrival order: ten bits from dibits 61..65, then ten from dibits 90..94. The data bits D = s0..s7 are MSB first. s8..s18 are the remainder of D·x^11 divided by x^11+x^10+x^6+x^5+x^4+x^2+1, MSB first. s19 makes the total parity even.
  - Up to two bit errors are corrected.
  - `color_o` = D[7:4] and the burst type = D[3:0].
  - Three errors set `st_err_o`.
- R7: The sign bits of sync dibits 66..89 form a 24-bit word, with the first dibit in bit 23; the low bits are ignored. `sync_class_o` reports this word's match: 1 = base pattern, 2 = direct slot 0, 3 = direct slot 1, 0 = none. If more than one pattern matches, the lowest nonzero code wins. Code 2 forces timeslot 0 and code 3 forces timeslot 1.
- R8: `fail_o` pulses with `done_o` exactly when `hdr_err_o` or `st_err_o` is set. On a failed burst, `color_o` and both burst-type outputs keep their values. `slot_o` also keeps its value when the header failed.
- R9: `color_o` changes only on a burst with both decodes good. The burst type goes to `burst_s0_o` or `burst_s1_o` according to the final timeslot.
- R10: After reset all outputs are 0. `done_o` is a single-cycle pulse in the cycle after the 144th dibit is accepted, and idle `valid_i` cycles inside a burst are skipped.
- R11: Dibits are ignored before the first `start_i`, after a burst completes, and in the cycle in which `start_i` is high. A `start_i` during a burst discards the partial burst and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | burst start pulse |
| valid_i | input | 1 | dibit strobe |
| dibit_i | input | 2 | received symbol |
| invert_i | input | 1 | polarity flip |
| mobile_i | input | 1 | force timeslot 0 |
| pat_bs_i | input | 24 | base-station sync sign pattern |
| pat_dm1_i | input | 24 | direct-mode slot 0 pattern |
| pat_dm2_i | input | 24 | direct-mode slot 1 pattern |
| done_o | output | 1 | burst complete pulse |
| hdr_err_o | output | 1 | access word uncorrectable |
| st_err_o | output | 1 | slot-type word uncorrectable |
| fail_o | output | 1 | error pulse |
| slot_o | output | 1 | timeslot |
| color_o | output | 4 | color code |
| burst_s0_o | output | 4 | burst type, slot 0 |
| burst_s1_o | output | 4 | burst type, slot 1 |
| sync_class_o | output | 2 | sync match class |
| hdr_o | output | 24 | de-interleaved header |
| payload_o | output | 196 | payload bits |

## Verification
The bench attacks:
- **Slot-type errors.** It places two and three errors in the slot-type word. A decoder with too small a search radius would drop good color codes, and one with too large a radius would accept a wrong one.
- **Timeslot overrides.** It checks the order of the overrides: header bit, then the mobile input, then direct-mode sync, with equal patterns used to test priority. A reversed priority would put the burst type into the wrong per-slot register.
- **Sync low bits.** Random low bits in the sync field expose a matcher that compares whole dibits.
- **Burst framing.** Aborted bursts, stray dibits while idle and in the start cycle, strobe gaps, and an inverted stream all shift or corrupt every field if the framing counter or the polarity flip is wrong. A second instance with detect-only header checking shows that header errors block updates.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int unsigned HDR_END   = 12;
  localparam int unsigned P1_END    = 61;
  localparam int unsigned ST1_END   = 66;
  localparam int unsigned SYNC_END  = 90;
  localparam int unsigned ST2_END   = 95;
  localparam int unsigned BURST_LEN = 144;
  localparam int unsigned HDR_BITS  = 2 * HDR_END;
  localparam int unsigned PAY_BITS  = 2 * (P1_END - HDR_END) + 2 * (BURST_LEN - ST2_END);
  localparam int unsigned ST_BITS   = 2 * (ST1_END - P1_END) + 2 * (ST2_END - SYNC_END);
  localparam int unsigned SYNC_W    = SYNC_END - ST1_END;
  localparam logic [10:0] GOLAY_POLY = 11'h475;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,
    SYNC_BASE = 2'd1,
    SYNC_DIR0 = 2'd2,
    SYNC_DIR1 = 2'd3
  } sync_class_e;

  localparam logic [4:0] HDR_POS [HDR_BITS] = '{
    5'd0, 5'd7, 5'd8, 5'd9, 5'd1, 5'd10, 5'd11, 5'd12, 5'd2, 5'd13, 5'd14, 5'd15,
    5'd3, 5'd16, 5'd4, 5'd17, 5'd18, 5'd19, 5'd5, 5'd20, 5'd21, 5'd22, 5'd6, 5'd23
  };

  // check bits {remainder[10:0], even parity} for a data byte
  function automatic logic [11:0] golay_check(input logic [7:0] d);
    logic [10:0] r;
    logic fb;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = d[i] ^ r[10];
      r  = {r[9:0], 1'b0};
      if (fb) r = r ^ GOLAY_POLY;
    end
    return {r, ^{d, r}};
  endfunction

  // syndrome produced by a single error at codeword bit i
  function automatic logic [11:0] golay_col(input int i);
    logic [19:0] e;
    e = 20'd1 << i;
    return golay_check(e[19:12]) ^ e[11:0];
  endfunction
endpackage

// File: rtl/bdf_ham74.sv
module bdf_ham74 #(
  parameter bit HDR_CORRECT = 1'b1,
  parameter int SEL         = 1
) (
  input  logic [6:0] acc_i,
  output logic       bit_o,
  output logic       err_o
);
  logic [2:0] syn;
  logic [2:0] col;

  assign syn = {acc_i[6] ^ acc_i[0] ^ acc_i[1] ^ acc_i[3],
                acc_i[5] ^ acc_i[1] ^ acc_i[2] ^ acc_i[3],
                acc_i[4] ^ acc_i[0] ^ acc_i[1] ^ acc_i[2]};

  always_comb begin
    case (SEL)
      0:       col = 3'b101;
      1:       col = 3'b111;
      2:       col = 3'b011;
      default: col = 3'b110;
    endcase
  end

  generate
    if (HDR_CORRECT) begin : g_fix
      assign bit_o = acc_i[SEL] ^ (syn == col);
      assign err_o = 1'b0;
    end else begin : g_detect
      assign bit_o = acc_i[SEL];
      assign err_o = |syn;
    end
  endgenerate
endmodule

// File: rtl/bdf_golay2008.sv
module bdf_golay2008
  import bdf_pkg::*;
(
  input  logic [19:0] cw_i,
  output logic [7:0]  data_o,
  output logic        err_o
);
  logic [11:0] syn;
  logic [19:0] fix;
  logic        hit;

  assign syn = golay_check(cw_i[19:12]) ^ cw_i[11:0];

  // weight-1 and weight-2 error patterns have unique syndromes
  always_comb begin
    fix = '0;
    hit = (syn == 12'd0);
    for (int i = 0; i < 20; i++) begin
      if (golay_col(i) == syn) begin
        fix = fix | (20'd1 << i);
        hit = 1'b1;
      end
      for (int j = i + 1; j < 20; j++) begin
        if ((golay_col(i) ^ golay_col(j)) == syn) begin
          fix = fix | (20'd1 << i) | (20'd1 << j);
          hit = 1'b1;
        end
      end
    end
  end

  assign data_o = cw_i[19:12] ^ fix[19:12];
  assign err_o  = ~hit;
endmodule

// File: rtl/bdf_sync_match.sv
module bdf_sync_match
  import bdf_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] sgn_i,
  input  logic [W-1:0] pat_bs_i,
  input  logic [W-1:0] pat_dm1_i,
  input  logic [W-1:0] pat_dm2_i,
  output sync_class_e  cls_o
);
  always_comb begin
    if (sgn_i == pat_bs_i)       cls_o = SYNC_BASE;
    else if (sgn_i == pat_dm1_i) cls_o = SYNC_DIR0;
    else if (sgn_i == pat_dm2_i) cls_o = SYNC_DIR1;
    else                         cls_o = SYNC_NONE;
  end
endmodule

// File: rtl/burst_deframer.sv
module burst_deframer
  import bdf_pkg::*;
#(
  parameter bit HDR_CORRECT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         valid_i,
  input  logic [1:0]   dibit_i,
  input  logic         invert_i,
  input  logic         mobile_i,
  input  logic [23:0]  pat_bs_i,
  input  logic [23:0]  pat_dm1_i,
  input  logic [23:0]  pat_dm2_i,
  output logic         done_o,
  output logic         hdr_err_o,
  output logic         st_err_o,
  output logic         fail_o,
  output logic         slot_o,
  output logic [3:0]   color_o,
  output logic [3:0]   burst_s0_o,
  output logic [3:0]   burst_s1_o,
  output logic [1:0]   sync_class_o,
  output logic [23:0]  hdr_o,
  output logic [195:0] payload_o
);
  localparam int CW = $clog2(BURST_LEN);

  logic                active_q, fin_q;
  logic [CW-1:0]       cnt_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [PAY_BITS-1:0] pay_q;
  logic [ST_BITS-1:0]  cw_q;
  logic [SYNC_W-1:0]   sgn_q;
  logic [1:0]          dib;
  logic                take;
  logic [CW-1:0]       pidx;
  logic                in_hdr, in_pay, in_st, in_sync;

  assign dib  = dibit_i ^ {invert_i, 1'b0};
  assign take = active_q && valid_i && !start_i;

  assign in_hdr  = cnt_q < CW'(HDR_END);
  assign in_pay  = (!in_hdr && cnt_q < CW'(P1_END)) || cnt_q >= CW'(ST2_END);
  assign in_st   = (cnt_q >= CW'(P1_END) && cnt_q < CW'(ST1_END)) ||
                   (cnt_q >= CW'(SYNC_END) && cnt_q < CW'(ST2_END));
  assign in_sync = cnt_q >= CW'(ST1_END) && cnt_q < CW'(SYNC_END);

  always_comb begin
    if (cnt_q < CW'(P1_END)) pidx = CW'((cnt_q - CW'(HDR_END)) << 1);
    else                     pidx = CW'(((cnt_q - CW'(ST2_END)) << 1) + CW'(PAY_BITS / 2));
  end

  // framing counter
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (take) begin
        if (cnt_q == CW'(BURST_LEN - 1)) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // field capture
  always_ff @(posedge clk) begin
    if (take) begin
      if (in_hdr) begin
        hdr_q[HDR_POS[{cnt_q[3:0], 1'b0}]] <= dib[1];
        hdr_q[HDR_POS[{cnt_q[3:0], 1'b1}]] <= dib[0];
      end
      if (in_pay) begin
        pay_q[pidx]         <= dib[1];
        pay_q[pidx | CW'(1)] <= dib[0];
      end
      if (in_st)   cw_q  <= {cw_q[ST_BITS-3:0], dib};
      if (in_sync) sgn_q <= {sgn_q[SYNC_W-2:0], dib[1]};
    end
  end

  logic        acc_slot, hdr_err;
  logic [7:0]  st_data;
  logic        st_err;
  sync_class_e cls;
  logic        slot_n;

  bdf_ham74 #(.HDR_CORRECT(HDR_CORRECT), .SEL(1)) u_ham (
    .acc_i (hdr_q[6:0]),
    .bit_o (acc_slot),
    .err_o (hdr_err)
  );

  bdf_golay2008 u_golay (
    .cw_i   (cw_q),
    .data_o (st_data),
    .err_o  (st_err)
  );

  bdf_sync_match #(.W(SYNC_W)) u_sync (
    .sgn_i     (sgn_q),
    .pat_bs_i  (pat_bs_i),
    .pat_dm1_i (pat_dm1_i),
    .pat_dm2_i (pat_dm2_i),
    .cls_o     (cls)
  );

  always_comb begin
    if (cls == SYNC_DIR0)      slot_n = 1'b0;
    else if (cls == SYNC_DIR1) slot_n = 1'b1;
    else if (mobile_i)         slot_n = 1'b0;
    else                       slot_n = acc_slot;
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      hdr_err_o    <= 1'b0;
      st_err_o     <= 1'b0;
      fail_o       <= 1'b0;
      slot_o       <= 1'b0;
      color_o      <= '0;
      burst_s0_o   <= '0;
      burst_s1_o   <= '0;
      sync_class_o <= '0;
      hdr_o        <= '0;
      payload_o    <= '0;
    end else begin
      done_o <= fin_q;
      fail_o <= fin_q && (hdr_err || st_err);
      if (fin_q) begin
        hdr_err_o    <= hdr_err;
        st_err_o     <= st_err;
        sync_class_o <= cls;
        hdr_o        <= hdr_q;
        payload_o    <= pay_q;
        if (!hdr_err) slot_o <= slot_n;
        if (!hdr_err && !st_err) begin
          color_o <= st_data[7:4];
          if (slot_n) burst_s1_o <= st_data[3:0];
          else        burst_s0_o <= st_data[3:0];
        end
      end
    end
  end
endmodule

// File: rtl/bdf_checker.sv
module bdf_checker (
  input logic       clk,
  input logic       rst,
  input logic       done_o,
  input logic       fail_o,
  input logic       hdr_err_o,
  input logic       slot_o,
  input logic [3:0] color_o,
  input logic [3:0] burst_s0_o,
  input logic [3:0] burst_s1_o,
  input logic [1:0] sync_class_o
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> done_o);

  a_r9_color_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(color_o) |-> (done_o && !fail_o));

  a_r9_burst0_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_s0_o) |-> (done_o && !fail_o && !slot_o));

  a_r9_burst1_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_s1_o) |-> (done_o && !fail_o && slot_o));

  a_r8_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot_o) |-> (done_o && !hdr_err_o));

  a_r7_dir0_slot: assert property (@(posedge clk) disable iff (rst)
    (done_o && !hdr_err_o && sync_class_o == 2'd2) |-> !slot_o);

  a_r7_dir1_slot: assert property (@(posedge clk) disable iff (rst)
    (done_o && !hdr_err_o && sync_class_o == 2'd3) |-> slot_o);
endmodule

bind burst_deframer bdf_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .hdr_err_o    (hdr_err_o),
  .slot_o       (slot_o),
  .color_o      (color_o),
  .burst_s0_o   (burst_s0_o),
  .burst_s1_o   (burst_s1_o),
  .sync_class_o (sync_class_o)
);

// File: tb/burst_deframer_tb_top.sv
`timescale 1ns/1ps
module burst_deframer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         start_i = 0, valid_i = 0, invert_i = 0, mobile_i = 0;
  logic [1:0]   dibit_i = 0;
  logic [23:0]  pat_bs_i = 24'hD5D7F7, pat_dm1_i = 24'h7F7D5D, pat_dm2_i = 24'hD7557F;
  logic         done_o, hdr_err_o, st_err_o, fail_o, slot_o;
  logic [3:0]   color_o, burst_s0_o, burst_s1_o;
  logic [1:0]   sync_class_o;
  logic [23:0]  hdr_o;
  logic [195:0] payload_o;
  logic         d2_done, d2_herr, d2_serr, d2_fail, d2_slot;
  logic [3:0]   d2_color, d2_b0, d2_b1;
  logic [1:0]   d2_cls;
  logic [23:0]  d2_hdr;
  logic [195:0] d2_pay;

  burst_deframer dut_i (.clk, .rst, .start_i, .valid_i, .dibit_i, .invert_i, .mobile_i,
    .pat_bs_i, .pat_dm1_i, .pat_dm2_i, .done_o, .hdr_err_o, .st_err_o, .fail_o, .slot_o,
    .color_o, .burst_s0_o, .burst_s1_o, .sync_class_o, .hdr_o, .payload_o);

  burst_deframer #(.HDR_CORRECT(1'b0)) dut_strict_i (.clk, .rst, .start_i, .valid_i, .dibit_i,
    .invert_i, .mobile_i, .pat_bs_i, .pat_dm1_i, .pat_dm2_i, .done_o(d2_done),
    .hdr_err_o(d2_herr), .st_err_o(d2_serr), .fail_o(d2_fail), .slot_o(d2_slot),
    .color_o(d2_color), .burst_s0_o(d2_b0), .burst_s1_o(d2_b1), .sync_class_o(d2_cls),
    .hdr_o(d2_hdr), .payload_o(d2_pay));

  int checks = 0, errors = 0;
  string scen = "reset";
  bit running = 0;
  int perm [24] = '{0,7,8,9,1,10,11,12,2,13,14,15,3,16,4,17,18,19,5,20,21,22,6,23};

  // ---------------- reference helpers ----------------
  function automatic bit [6:0] ham_enc(bit [3:0] d);
    bit [6:0] c;
    c[3:0] = d;
    c[4] = d[0] ^ d[1] ^ d[2];
    c[5] = d[1] ^ d[2] ^ d[3];
    c[6] = d[0] ^ d[1] ^ d[3];
    return c;
  endfunction

  function automatic bit [19:0] gol_enc(bit [7:0] d);
    bit [18:0] v;
    v = {d, 11'b0};
    for (int k = 18; k >= 11; k--)
      if (v[k]) v = v ^ (19'(12'hC75) << (k - 11));
    return {d, v[10:0], ^{d, v[10:0]}};
  endfunction

  // ---------------- model ----------------
  bit [1:0] mdib [144];
  int  mcnt = 0;
  bit  mact = 0, mpend = 0;
  bit  e_done, e_herr, e_serr, e_fail, e_slot, e2_herr, e2_fail;
  bit [3:0]   e_color, e_b0, e_b1;
  bit [1:0]   e_cls;
  bit [23:0]  e_hdr;
  bit [195:0] e_pay;

  task automatic model_finish();
    bit b [288];
    bit [6:0] acc;
    bit [19:0] rx;
    bit [23:0] sg;
    int best, bd, gbest, gd;
    bit hok, hstrict_ok, sok, sl;
    for (int i = 0; i < 144; i++) begin b[2*i] = mdib[i][1]; b[2*i+1] = mdib[i][0]; end
    for (int n = 0; n < 24; n++) e_hdr[perm[n]] = b[n];
    for (int k = 0; k < 98; k++) begin e_pay[k] = b[24+k]; e_pay[98+k] = b[190+k]; end
    acc = e_hdr[6:0];
    best = 0; bd = 99;
    for (int d = 0; d < 16; d++)
      if ($countones(ham_enc(4'(d)) ^ acc) < bd) begin bd = $countones(ham_enc(4'(d)) ^ acc); best = d; end
    hok = 1; hstrict_ok = (bd == 0);
    for (int k = 0; k < 10; k++) begin rx[19-k] = b[122+k]; rx[9-k] = b[180+k]; end
    gbest = 0; gd = 99;
    for (int d = 0; d < 256; d++)
      if ($countones(gol_enc(8'(d)) ^ rx) < gd) begin gd = $countones(gol_enc(8'(d)) ^ rx); gbest = d; end
    sok = (gd <= 2);
    for (int i = 0; i < 24; i++) sg[23-i] = b[132+2*i];
    if (sg == pat_bs_i) e_cls = 2'd1;
    else if (sg == pat_dm1_i) e_cls = 2'd2;
    else if (sg == pat_dm2_i) e_cls = 2'd3;
    else e_cls = 2'd0;
    sl = (4'(best) >> 1) & 1'b1;
    if (mobile_i) sl = 0;
    if (e_cls == 2'd2) sl = 0;
    if (e_cls == 2'd3) sl = 1;
    e_herr = !hok; e_serr = !sok; e_fail = !hok || !sok;
    e2_herr = !hstrict_ok; e2_fail = !hstrict_ok || !sok;
    e_slot = sl;
    if (sok) begin
      e_color = 4'(gbest >> 4);
      if (sl) e_b1 = 4'(gbest); else e_b0 = 4'(gbest);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mact = 0; mcnt = 0; mpend = 0; e_done = 0; e_herr = 0; e_serr = 0; e_fail = 0;
      e_slot = 0; e_color = 0; e_b0 = 0; e_b1 = 0; e_cls = 0; e_hdr = 0; e_pay = 0;
      e2_herr = 0; e2_fail = 0;
    end else begin
      e_done = 0; e_fail = 0; e2_fail = 0;
      if (mpend) begin mpend = 0; e_done = 1; model_finish(); end
      if (start_i) begin mact = 1; mcnt = 0; end
      else if (mact && valid_i) begin
        mdib[mcnt] = dibit_i ^ {invert_i, 1'b0};
        mcnt++;
        if (mcnt == 144) begin mact = 0; mpend = 1; end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [195:0] act, input logic [195:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h", tag, what, scen, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && running) begin
      chk(done_o === e_done, "R10", "done", 196'(done_o), 196'(e_done));
      chk(payload_o === e_pay, "R1", "payload", payload_o, e_pay);
      chk(hdr_o === e_hdr, "R3", "header", 196'(hdr_o), 196'(e_hdr));
      chk(slot_o === e_slot, "R4", "slot", 196'(slot_o), 196'(e_slot));
      chk(hdr_err_o === e_herr, "R4", "hdr_err", 196'(hdr_err_o), 196'(e_herr));
      chk(color_o === e_color, "R6", "color", 196'(color_o), 196'(e_color));
      chk(st_err_o === e_serr, "R6", "st_err", 196'(st_err_o), 196'(e_serr));
      chk(sync_class_o === e_cls, "R7", "sync_class", 196'(sync_class_o), 196'(e_cls));
      chk(fail_o === e_fail, "R8", "fail", 196'(fail_o), 196'(e_fail));
      chk(burst_s0_o === e_b0, "R9", "burst_s0", 196'(burst_s0_o), 196'(e_b0));
      chk(burst_s1_o === e_b1, "R9", "burst_s1", 196'(burst_s1_o), 196'(e_b1));
      chk(d2_herr === e2_herr, "R4", "strict hdr_err", 196'(d2_herr), 196'(e2_herr));
      chk(d2_fail === e2_fail, "R8", "strict fail", 196'(d2_fail), 196'(e2_fail));
    end
  end

  // ---------------- stimulus ----------------
  bit [1:0] tb_dib [144];

  task automatic make_burst(input bit [3:0] acc, input bit [7:0] st, input bit [23:0] sg,
                            input int gerr, input int herr);
    bit b [288];
    bit [23:0] h;
    bit [19:0] cw;
    int flips [3] = '{3, 11, 17};
    h = 24'($urandom);
    h[6:0] = ham_enc(acc);
    if (herr >= 0) h[herr] = ~h[herr];
    for (int n = 0; n < 24; n++) b[n] = h[perm[n]];
    for (int k = 24; k < 288; k++) b[k] = 1'($urandom);
    cw = gol_enc(st);
    for (int f = 0; f < gerr; f++) cw[flips[f]] = ~cw[flips[f]];
    for (int k = 0; k < 10; k++) begin b[122+k] = cw[19-k]; b[180+k] = cw[9-k]; end
    for (int i = 0; i < 24; i++) b[132+2*i] = sg[23-i];
    for (int i = 0; i < 144; i++) tb_dib[i] = {b[2*i], b[2*i+1]};
  endtask

  task automatic send_burst(input bit inv, input int gap);
    invert_i = inv;
    start_i = 1; valid_i = 1; dibit_i = 2'($urandom);
    @(posedge clk); #1;
    start_i = 0;
    for (int i = 0; i < 144; i++) begin
      if (gap > 0 && (i % gap) == 1) begin valid_i = 0; @(posedge clk); #1; end
      valid_i = 1; dibit_i = tb_dib[i] ^ {inv, 1'b0};
      @(posedge clk); #1;
    end
    valid_i = 0;
    repeat (4) @(posedge clk);
    #1;
    invert_i = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0; running = 1;
    // R10 reset values, R11 idle dibits ignored
    scen = "R11 idle";
    repeat (6) begin valid_i = 1; dibit_i = 2'($urandom); @(posedge clk); #1; end
    valid_i = 0;
    scen = "R1 base sync";
    make_burst(4'b0010, 8'hA5, pat_bs_i, 0, -1); send_burst(0, 0);
    scen = "R7 direct slot0";
    make_burst(4'b0010, 8'h3C, pat_dm1_i, 0, -1); send_burst(0, 0);
    scen = "R7 direct slot1";
    make_burst(4'b0000, 8'h69, pat_dm2_i, 0, -1); send_burst(0, 0);
    scen = "R5 mobile";
    mobile_i = 1;
    make_burst(4'b1010, 8'h5A, 24'h000000, 0, -1); send_burst(0, 0);
    scen = "R5 mobile with direct slot1";
    make_burst(4'b0000, 8'hE1, pat_dm2_i, 0, -1); send_burst(0, 0);
    mobile_i = 0;
    scen = "R2 invert";
    make_burst(4'b0110, 8'h96, pat_bs_i, 0, -1); send_burst(1, 0);
    scen = "R6 two errors";
    make_burst(4'b0011, 8'h7E, pat_dm1_i, 2, -1); send_burst(0, 0);
    scen = "R8 three errors";
    make_burst(4'b0010, 8'h18, pat_bs_i, 3, -1); send_burst(0, 0);
    scen = "R4 header one error";
    make_burst(4'b0010, 8'hC3, 24'h123456, 0, 1); send_burst(0, 0);
    scen = "R4 header parity error";
    make_burst(4'b1101, 8'h4B, 24'h0F0F0F, 0, 5); send_burst(0, 0);
    scen = "R11 abort";
    start_i = 1; @(posedge clk); #1; start_i = 0;
    for (int i = 0; i < 50; i++) begin valid_i = 1; dibit_i = 2'($urandom); @(posedge clk); #1; end
    make_burst(4'b0111, 8'hD2, pat_bs_i, 0, -1); send_burst(0, 0);
    scen = "R10 strobe gaps";
    make_burst(4'b1000, 8'h2D, pat_dm2_i, 1, -1); send_burst(0, 3);
    scen = "R7 priority";
    pat_dm1_i = pat_bs_i;
    make_burst(4'b0000, 8'hF0, pat_bs_i, 0, -1); send_burst(0, 0);
    pat_dm1_i = 24'h7F7D5D;
    scen = "R9 slot0 burst";
    make_burst(4'b0000, 8'h87, 24'hABCDEF, 0, -1); send_burst(0, 0);
    scen = "R11 after burst";
    repeat (8) begin valid_i = 1; dibit_i = 2'($urandom); @(posedge clk); #1; end
    valid_i = 0;
    repeat (4) @(posedge clk);
    #1 running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule